// File: doc/BRIEF.md
# Processor Core Power-Up Sequencer

This block takes one processor core from its powered-off condition to running on a single start pulse. It drives the core's isolation clamp, the clamp on the core's memories, the memory head-switch enable, the staged head-switch enables, the clock gate, the core reset and the power-on reset. A fixed series of steps with timed waits brings the core up safely. The head-switch stages turn on one per clock to limit inrush current. Each of the three waits lasts a fixed 2 µs, which the block converts to clock cycles from a clock-frequency parameter.

A combinational read port gives a register view of the live control state. One word holds the eight core control bits. A second word holds the head-switch enable flag and the number of stages that are currently on. All other addresses read as zero. A start pulse is ignored while a sequence is running. The done flag holds until the next start or reset. Reset asserts asynchronously and is released synchronously. Reset returns every output to the fully clamped, fully reset state.

Top module: `core_pwrup_seq`

## Requirements
- R1: During and after reset, with no start since, the control byte reads 0x33: core clamp, memory clamp, core reset and power-on reset high, all other control bits low. All head-switch stages are off, and busy and done are low. Bit order of the control byte: 0 core clamp, 1 memory clamp, 2 L1 reset disable, 3 memory head switch, 4 core reset, 5 power-on reset, 6 clock gate, 7 powered up.
- R2: A start pulse sampled at clock edge E0 puts the starting pattern 0x33 on the outputs after E0, with busy high. After E1 the head-switch enable flag is high. After edge E1+k, the lowest k stages of `hs_en_o` are on, as a thermometer code, for k up to HS_COUNT.
- R3: The first wait begins after edge E2+HS_COUNT, once all stages are on. The wait lasts WAIT_US×CLK_MHZ cycles (W). The memory clamp is then released, giving control byte 0x31 after E2+HS_COUNT+W.
- R4: One cycle after the memory clamp is released, the memory head switch turns on (0x39). It holds for W cycles.
- R5: The core clamp is then released (0x38) for W cycles. After that, core reset and power-on reset fall in the same cycle (0x08).
- R6: One cycle after the resets are released, the powered-up bit is set (0x88). Done goes high and busy goes low. Busy and done are never high together.
- R7: A start pulse sampled while busy is ignored. This holds even when it coincides with a step transition. The sequence timing is unchanged.
- R8: Done and the final outputs hold while no start arrives. A start sampled while done restarts the sequence from the starting pattern. In that case done falls, busy rises and all stages turn off.
- R9: A read at address 0x04 returns the control byte in bits 7:0. A read at address 0x14 returns the head-switch enable flag in bit 0 and the number of stages on in bits 28:24. Every other address reads zero.
- R10: Asserting reset in the middle of a sequence returns the outputs to the R1 state at once. No sequence runs after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start request, one-cycle pulse |
| rd_addr_i | input | ADDR_W | Register read address (byte offset) |
| rd_data_o | output | DATA_W | Register read data, combinational |
| core_clamp_o | output | 1 | Core isolation clamp |
| mem_clamp_o | output | 1 | Core memory clamp |
| l1_rst_dis_o | output | 1 | L1 reset disable (held low) |
| mem_hs_en_o | output | 1 | Memory head-switch enable |
| core_rst_o | output | 1 | Core reset |
| por_rst_o | output | 1 | Core power-on reset |
| clk_gate_o | output | 1 | Core clock gate (held low, clock running) |
| pwrd_up_o | output | 1 | Powered-up indication |
| hs_en_o | output | HS_STAGES | Per-stage head-switch enables |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence completed |

## Verification
A start request can land in the same cycle as a step transition of the sequence. The bench provokes this with pulses that are sampled on the edge where the first wait expires and the memory clamp falls. It also sends a pulse sampled on the edge where the resets have just dropped and the powered-up bit is about to rise. In both cases the outputs in the following cycles must match the undisturbed timetable exactly, with no return to the starting pattern. A start sampled on the edge after done has risen must instead restart the sequence.

// File: rtl/cps_pkg.sv
package cps_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_INIT,
    ST_RAMP,
    ST_WAIT1,
    ST_MEMREL,
    ST_WAIT2,
    ST_WAIT3,
    ST_RSTREL,
    ST_DONE
  } cps_state_e;

  // bit 7 .. bit 0 of the control word
  typedef struct packed {
    logic pwrd_up;
    logic clk_gate;
    logic por_rst;
    logic core_rst;
    logic mem_hs;
    logic l1_rst_dis;
    logic mem_clamp;
    logic core_clamp;
  } cps_ctrl_t;

  localparam cps_ctrl_t CTRL_START = '{
    pwrd_up:    1'b0,
    clk_gate:   1'b0,
    por_rst:    1'b1,
    core_rst:   1'b1,
    mem_hs:     1'b0,
    l1_rst_dis: 1'b0,
    mem_clamp:  1'b1,
    core_clamp: 1'b1
  };

  localparam int OFS_CTRL  = 'h04;
  localparam int OFS_PGATE = 'h14;
  localparam int CNT_LSB   = 24;

  function automatic logic is_wait(input cps_state_e s);
    return (s == ST_WAIT1) || (s == ST_WAIT2) || (s == ST_WAIT3);
  endfunction

  function automatic cps_ctrl_t ctrl_for_state(input cps_state_e s);
    cps_ctrl_t c;
    c = CTRL_START;
    case (s)
      ST_MEMREL: begin
        c.mem_clamp = 1'b0;
      end
      ST_WAIT2: begin
        c.mem_clamp = 1'b0;
        c.mem_hs    = 1'b1;
      end
      ST_WAIT3: begin
        c.mem_clamp  = 1'b0;
        c.mem_hs     = 1'b1;
        c.core_clamp = 1'b0;
      end
      ST_RSTREL: begin
        c.mem_clamp  = 1'b0;
        c.mem_hs     = 1'b1;
        c.core_clamp = 1'b0;
        c.core_rst   = 1'b0;
        c.por_rst    = 1'b0;
      end
      ST_DONE: begin
        c.mem_clamp  = 1'b0;
        c.mem_hs     = 1'b1;
        c.core_clamp = 1'b0;
        c.core_rst   = 1'b0;
        c.por_rst    = 1'b0;
        c.pwrd_up    = 1'b1;
      end
      default: c = CTRL_START;
    endcase
    return c;
  endfunction

  function automatic logic hsw_for_state(input cps_state_e s);
    return (s != ST_IDLE) && (s != ST_INIT);
  endfunction

endpackage

// File: rtl/cps_rst_sync.sv
module cps_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sn = sync_q[1];

endmodule

// File: rtl/cps_wait_timer.sv
module cps_wait_timer #(
  parameter int WAIT_CYCLES = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic expired_o
);

  localparam int TW = (WAIT_CYCLES > 1) ? $clog2(WAIT_CYCLES) : 1;
  localparam logic [TW-1:0] LOAD_VAL = TW'(WAIT_CYCLES - 1);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          run_q, run_d;
  logic          cnt_en;

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    if (load_i) begin
      cnt_d = LOAD_VAL;
      run_d = 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) begin
        run_d = 1'b0;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  assign cnt_en = load_i | run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  assign expired_o = run_q & (cnt_q == '0);

endmodule

// File: rtl/cps_hs_ramp.sv
module cps_hs_ramp #(
  parameter int STAGES = 16,
  parameter int COUNT  = 16,
  parameter int CW     = $clog2(STAGES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              step_i,
  output logic [STAGES-1:0] hs_en_o,
  output logic [CW-1:0]     count_o,
  output logic              full_o
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign full_o = (cnt_q == CW'(COUNT));

  always_comb begin
    cnt_en = clr_i | (step_i & ~full_o);
    cnt_d  = clr_i ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    assign hs_en_o[g] = (cnt_q > CW'(g));
  end

  assign count_o = cnt_q;

endmodule

// File: rtl/cps_regmap.sv
module cps_regmap
  import cps_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CW     = 5
) (
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  cps_ctrl_t         ctrl_i,
  input  logic              hsw_i,
  input  logic [CW-1:0]     count_i,
  output logic [DATA_W-1:0] rd_data_o
);

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == ADDR_W'(OFS_CTRL)) begin
      rd_data_o[7:0] = ctrl_i;
    end else if (rd_addr_i == ADDR_W'(OFS_PGATE)) begin
      rd_data_o[0]             = hsw_i;
      rd_data_o[CNT_LSB +: CW] = count_i;
    end
  end

endmodule

// File: rtl/core_pwrup_seq.sv
module core_pwrup_seq
  import cps_pkg::*;
#(
  parameter int CLK_MHZ   = 100,
  parameter int WAIT_US   = 2,
  parameter int HS_STAGES = 16,
  parameter int HS_COUNT  = 16,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [ADDR_W-1:0]    rd_addr_i,
  output logic [DATA_W-1:0]    rd_data_o,
  output logic                 core_clamp_o,
  output logic                 mem_clamp_o,
  output logic                 l1_rst_dis_o,
  output logic                 mem_hs_en_o,
  output logic                 core_rst_o,
  output logic                 por_rst_o,
  output logic                 clk_gate_o,
  output logic                 pwrd_up_o,
  output logic [HS_STAGES-1:0] hs_en_o,
  output logic                 busy_o,
  output logic                 done_o
);

  localparam int WAIT_CYCLES = WAIT_US * CLK_MHZ;
  localparam int HS_CW       = $clog2(HS_STAGES + 1);

  logic             rst_sn;
  cps_state_e       state_q, state_d;
  cps_ctrl_t        ctrl_q, ctrl_d;
  logic             hsw_q, hsw_d;
  logic             busy_q, busy_d;
  logic             done_q, done_d;
  logic             step_en;
  logic             tmr_load;
  logic             tmr_expired;
  logic             ramp_clr;
  logic             ramp_step;
  logic             ramp_full;
  logic [HS_CW-1:0] ramp_count;

  cps_rst_sync u_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:   if (start_i)     state_d = ST_INIT;
      ST_INIT:                    state_d = ST_RAMP;
      ST_RAMP:   if (ramp_full)   state_d = ST_WAIT1;
      ST_WAIT1:  if (tmr_expired) state_d = ST_MEMREL;
      ST_MEMREL:                  state_d = ST_WAIT2;
      ST_WAIT2:  if (tmr_expired) state_d = ST_WAIT3;
      ST_WAIT3:  if (tmr_expired) state_d = ST_RSTREL;
      ST_RSTREL:                  state_d = ST_DONE;
      ST_DONE:   if (start_i)     state_d = ST_INIT;
      default:                    state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    step_en   = (state_d != state_q);
    ctrl_d    = ctrl_for_state(state_d);
    hsw_d     = hsw_for_state(state_d);
    busy_d    = (state_d != ST_IDLE) && (state_d != ST_DONE);
    done_d    = (state_d == ST_DONE);
    tmr_load  = step_en && is_wait(state_d);
    ramp_clr  = step_en && (state_d == ST_INIT);
    ramp_step = (state_q == ST_RAMP);
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q <= ST_IDLE;
      ctrl_q  <= CTRL_START;
      hsw_q   <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else if (step_en) begin
      state_q <= state_d;
      ctrl_q  <= ctrl_d;
      hsw_q   <= hsw_d;
      busy_q  <= busy_d;
      done_q  <= done_d;
    end
  end

  cps_wait_timer #(
    .WAIT_CYCLES (WAIT_CYCLES)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_sn),
    .load_i    (tmr_load),
    .expired_o (tmr_expired)
  );

  cps_hs_ramp #(
    .STAGES (HS_STAGES),
    .COUNT  (HS_COUNT),
    .CW     (HS_CW)
  ) u_ramp (
    .clk     (clk),
    .rst_n   (rst_sn),
    .clr_i   (ramp_clr),
    .step_i  (ramp_step),
    .hs_en_o (hs_en_o),
    .count_o (ramp_count),
    .full_o  (ramp_full)
  );

  cps_regmap #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CW     (HS_CW)
  ) u_regs (
    .rd_addr_i (rd_addr_i),
    .ctrl_i    (ctrl_q),
    .hsw_i     (hsw_q),
    .count_i   (ramp_count),
    .rd_data_o (rd_data_o)
  );

  assign core_clamp_o = ctrl_q.core_clamp;
  assign mem_clamp_o  = ctrl_q.mem_clamp;
  assign l1_rst_dis_o = ctrl_q.l1_rst_dis;
  assign mem_hs_en_o  = ctrl_q.mem_hs;
  assign core_rst_o   = ctrl_q.core_rst;
  assign por_rst_o    = ctrl_q.por_rst;
  assign clk_gate_o   = ctrl_q.clk_gate;
  assign pwrd_up_o    = ctrl_q.pwrd_up;
  assign busy_o       = busy_q;
  assign done_o       = done_q;

endmodule

// File: rtl/cps_chk.sv
module cps_chk #(
  parameter int HS_STAGES = 16,
  parameter int HS_COUNT  = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start_i,
  input logic                 core_clamp_o,
  input logic                 mem_clamp_o,
  input logic                 mem_hs_en_o,
  input logic                 core_rst_o,
  input logic                 por_rst_o,
  input logic                 pwrd_up_o,
  input logic [HS_STAGES-1:0] hs_en_o,
  input logic                 busy_o,
  input logic                 done_o
);

  AST_HS_THERMO: assert property (@(posedge clk) disable iff (!rst_n)
    (((hs_en_o + 1) & hs_en_o) == 0)); // R2

  AST_HS_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(hs_en_o) <= $countones($past(hs_en_o)) + 1)); // R2

  AST_MEMCLAMP_AFTER_RAMP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_clamp_o) |-> ($countones(hs_en_o) == HS_COUNT)); // R3

  AST_MEMHS_UNCLAMPED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_hs_en_o |-> !mem_clamp_o); // R4

  AST_CLAMP_AFTER_MEMHS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_clamp_o) |-> mem_hs_en_o); // R5

  AST_RST_AFTER_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_rst_o) |-> (!core_clamp_o && !$past(core_clamp_o) && !por_rst_o)); // R5

  AST_PWRUP_AFTER_RST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwrd_up_o) |-> (!core_rst_o && !$past(core_rst_o) && !$past(por_rst_o))); // R6

  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && done_o)); // R6

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !mem_clamp_o) |=> !mem_clamp_o); // R7

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> done_o); // R8

endmodule

bind core_pwrup_seq cps_chk #(
  .HS_STAGES (HS_STAGES),
  .HS_COUNT  (HS_COUNT)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .core_clamp_o (core_clamp_o),
  .mem_clamp_o  (mem_clamp_o),
  .mem_hs_en_o  (mem_hs_en_o),
  .core_rst_o   (core_rst_o),
  .por_rst_o    (por_rst_o),
  .pwrd_up_o    (pwrd_up_o),
  .hs_en_o      (hs_en_o),
  .busy_o       (busy_o),
  .done_o       (done_o)
);

// File: tb/sim_core_pwrup_seq.sv
module sim_core_pwrup_seq;

  localparam int CLK_PERIOD = 10;
  localparam int HS_STAGES  = 16;
  localparam int HS_COUNT   = 16;

  typedef struct packed {
    logic [7:0] t;
    logic [7:0] ctrl;
    logic [4:0] hs;
    logic       hsw;
    logic       busy;
    logic       done;
    logic [3:0] req;
  } vec_t;

  // timetable after a start sampled at edge E0, wait = 4 cycles, 16 stages
  localparam int NVEC = 15;
  localparam vec_t VEC [NVEC] = '{
    '{8'd0,  8'h33, 5'd0,  1'b0, 1'b1, 1'b0, 4'd2},
    '{8'd1,  8'h33, 5'd0,  1'b1, 1'b1, 1'b0, 4'd2},
    '{8'd2,  8'h33, 5'd1,  1'b1, 1'b1, 1'b0, 4'd2},
    '{8'd9,  8'h33, 5'd8,  1'b1, 1'b1, 1'b0, 4'd2},
    '{8'd17, 8'h33, 5'd16, 1'b1, 1'b1, 1'b0, 4'd2},
    '{8'd18, 8'h33, 5'd16, 1'b1, 1'b1, 1'b0, 4'd3},
    '{8'd21, 8'h33, 5'd16, 1'b1, 1'b1, 1'b0, 4'd3},
    '{8'd22, 8'h31, 5'd16, 1'b1, 1'b1, 1'b0, 4'd3},
    '{8'd23, 8'h39, 5'd16, 1'b1, 1'b1, 1'b0, 4'd4},
    '{8'd26, 8'h39, 5'd16, 1'b1, 1'b1, 1'b0, 4'd4},
    '{8'd27, 8'h38, 5'd16, 1'b1, 1'b1, 1'b0, 4'd5},
    '{8'd30, 8'h38, 5'd16, 1'b1, 1'b1, 1'b0, 4'd5},
    '{8'd31, 8'h08, 5'd16, 1'b1, 1'b1, 1'b0, 4'd5},
    '{8'd32, 8'h88, 5'd16, 1'b1, 1'b0, 1'b1, 4'd6},
    '{8'd40, 8'h88, 5'd16, 1'b1, 1'b0, 1'b1, 4'd8}
  };

  logic                 clk;
  logic                 rst_n;
  logic                 start_i;
  logic [7:0]           rd_addr_i;
  logic [31:0]          rd_data_o;
  logic                 core_clamp_o, mem_clamp_o, l1_rst_dis_o, mem_hs_en_o;
  logic                 core_rst_o, por_rst_o, clk_gate_o, pwrd_up_o;
  logic [HS_STAGES-1:0] hs_en_o;
  logic                 busy_o, done_o;

  int n_cmp;
  int n_bad;
  int cur;

  core_pwrup_seq #(
    .CLK_MHZ   (2),
    .WAIT_US   (2),
    .HS_STAGES (HS_STAGES),
    .HS_COUNT  (HS_COUNT),
    .ADDR_W    (8),
    .DATA_W    (32)
  ) u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .rd_addr_i    (rd_addr_i),
    .rd_data_o    (rd_data_o),
    .core_clamp_o (core_clamp_o),
    .mem_clamp_o  (mem_clamp_o),
    .l1_rst_dis_o (l1_rst_dis_o),
    .mem_hs_en_o  (mem_hs_en_o),
    .core_rst_o   (core_rst_o),
    .por_rst_o    (por_rst_o),
    .clk_gate_o   (clk_gate_o),
    .pwrd_up_o    (pwrd_up_o),
    .hs_en_o      (hs_en_o),
    .busy_o       (busy_o),
    .done_o       (done_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] pbyte();
    return {pwrd_up_o, clk_gate_o, por_rst_o, core_rst_o,
            mem_hs_en_o, l1_rst_dis_o, mem_clamp_o, core_clamp_o};
  endfunction

  function automatic string tag(input logic [3:0] r);
    case (r)
      4'd2:    return "R2";
      4'd3:    return "R3";
      4'd4:    return "R4";
      4'd5:    return "R5";
      4'd6:    return "R6";
      4'd8:    return "R8";
      default: return "R?";
    endcase
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    rd_addr_i = a;
    #1;
    d = rd_data_o;
  endtask

  task automatic goto_t(input int t);
    while (cur < t) begin
      @(negedge clk);
      cur++;
    end
  endtask

  task automatic start_seq();
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    cur = 0;
  endtask

  task automatic pulse_at(input int t);
    goto_t(t);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    cur++;
  endtask

  task automatic chk_state(input string req, input logic [7:0] ctrl,
                           input int hs, input logic hsw,
                           input logic busy, input logic done);
    logic [31:0] d;
    chk(req, "control outputs", {24'd0, pbyte()}, {24'd0, ctrl});
    chk(req, "stage enables", {16'd0, hs_en_o}, (32'd1 << hs) - 32'd1);
    chk(req, "busy", {31'd0, busy_o}, {31'd0, busy});
    chk(req, "done", {31'd0, done_o}, {31'd0, done});
    rd(8'h04, d);
    chk(req, "read 0x04", d, {24'd0, ctrl});
    rd(8'h14, d);
    chk(req, "read 0x14", d, (32'(hs) << 24) | {31'd0, hsw});
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_cmp++;
    n_bad++;
    $display("FAIL R6 watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    n_cmp     = 0;
    n_bad     = 0;
    cur       = 0;
    rst_n     = 1'b0;
    start_i   = 1'b0;
    rd_addr_i = 8'h00;

    // R1: reset state, during and after reset
    repeat (3) @(negedge clk);
    chk_state("R1", 8'h33, 0, 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk_state("R1", 8'h33, 0, 1'b0, 1'b0, 1'b0);

    // timetable walk: R2 .. R6, R8
    start_seq();
    for (int i = 0; i < NVEC; i++) begin
      goto_t(int'(VEC[i].t));
      chk_state(tag(VEC[i].req), VEC[i].ctrl, int'(VEC[i].hs),
                VEC[i].hsw, VEC[i].busy, VEC[i].done);
    end

    // R9: unmapped addresses read zero with live state non-zero
    rd(8'h00, d); chk("R9", "read 0x00", d, 32'd0);
    rd(8'h08, d); chk("R9", "read 0x08", d, 32'd0);
    rd(8'h10, d); chk("R9", "read 0x10", d, 32'd0);
    rd(8'h18, d); chk("R9", "read 0x18", d, 32'd0);
    rd(8'hFF, d); chk("R9", "read 0xFF", d, 32'd0);
    rd(8'h14, d); chk("R9", "read 0x14 full", d, 32'h1000_0001);

    // R8: restart from done
    start_seq();
    chk_state("R8", 8'h33, 0, 1'b0, 1'b1, 1'b0);

    // R7: starts while busy, including on step edges
    pulse_at(5);
    goto_t(7);
    chk_state("R7", 8'h33, 6, 1'b1, 1'b1, 1'b0);
    pulse_at(21);
    chk_state("R7", 8'h31, 16, 1'b1, 1'b1, 1'b0);
    pulse_at(24);
    goto_t(27);
    chk_state("R7", 8'h38, 16, 1'b1, 1'b1, 1'b0);
    pulse_at(31);
    chk_state("R7", 8'h88, 16, 1'b1, 1'b0, 1'b1);
    goto_t(33);
    chk_state("R7", 8'h88, 16, 1'b1, 1'b0, 1'b1);

    // R10: reset in the middle of a sequence
    start_seq();
    goto_t(25);
    rst_n = 1'b0;
    #1;
    chk_state("R10", 8'h33, 0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (40) @(negedge clk);
    chk_state("R10", 8'h33, 0, 1'b0, 1'b0, 1'b0);

    // full run after reset still reaches done on time
    start_seq();
    goto_t(32);
    chk_state("R6", 8'h88, 16, 1'b1, 1'b0, 1'b1);

    finish_run();
  end

endmodule